// File: doc/BRIEF.md
# Register-Configured Pad Function Multiplexer

This block sits between a group of on-chip peripherals and a row of IO pads. Each pad can carry one of several peripheral functions. A function-select register for each pad picks which function owns that pad. The selected function's 8-bit drive-and-enable bundle goes out to the pad cell. The pad's input level is steered back only to the selected function's input line.

Software programs the select registers through a single-cycle register port. A fixed slice of the address picks the register. Writes keep only as many low data bits as the pad's select field holds. Reads return the field zero-extended to the full data width. An access to an index that has no register raises an error flag. A select code beyond the pad's last function parks the pad in a safe, fully disabled state.

Top module: `pad_pinmux`

## Requirements
- R1: The 8-bit bundle of the selected function reaches the pad unchanged. Its bit order is: bit 7 output value, bit 6 output enable, bit 5 input enable, bit 4 pull-up, bit 3 pull-down, bit 2 strong drive, bit 1 push-pull, bit 0 open-drain.
- R2: Each pad's select field is ceil(log2(function count)) bits wide, and at least 1 bit. The default function counts for pads 0..3 are 4, 3, 2 and 6, which give widths 2, 2, 1 and 3. A write keeps only that many low data bits.
- R3: After reset every select field is 0, so every pad carries function 0.
- R4: Address bits [4:2] form the register index, and index i selects pad i's register. All other address bits are ignored.
- R5: A write to a valid index raises no error. The new select drives the pad after the clock edge that ends the write cycle, and not before.
- R6: A read of a valid index returns the select field zero-extended to 32 bits, with the error flag low. Both are combinational in the access cycle.
- R7: An access with an index of 4 or more sets the error flag, leaves every select field unchanged and reads as 0.
- R8: A select code at or above the pad's function count drives the all-zero bundle onto the pad.
- R9: Function line f of pad p, at fn_in_o[p*8+f], follows pad_in_i[p] only while pad p selects a valid function f. Otherwise it reads 0.
- R10: With acc_en low, nothing is written, the error flag is 0 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Access address; bits [4:2] are the index |
| acc_wdata | input | 32 | Write data |
| acc_err | output | 1 | Access targets an unmapped index |
| acc_rdata | output | 32 | Read data, zero-extended select |
| fn_ctrl_i | input | 256 | Bundle of function f for pad p at bits [(p*8+f)*8 +: 8] |
| pad_in_i | input | 4 | Input level seen at each pad |
| pad_ctrl_o | output | 32 | Bundle driven to pad p at bits [p*8 +: 8] |
| fn_in_o | output | 32 | Pad input returned to function f of pad p at bit p*8+f |

## Verification
Several properties are checked on every cycle by assertions:
- routing of the selected bundle and the zero bundle for out-of-range codes;
- at most one function line active per pad;
- truncation of written data;
- unchanged registers after an unmapped write;
- a quiet port when idle.

Other behaviour can only be shown by the bench's scenarios:
- the one-cycle delay between a write and the pad change;
- the exact bit order of the bundle;
- that address bits outside the index slice are ignored;
- read-back of each pad's field through the port after mixed sequences of writes.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int BUNDLE_W = 8;

  // Pad drive/enable bundle, MSB first.
  typedef struct packed {
    logic out_val;
    logic out_en;
    logic in_en;
    logic pull_up;
    logic pull_dn;
    logic drive_hi;
    logic push_pull;
    logic open_drain;
  } pad_bundle_t;

  localparam pad_bundle_t SAFE_BUNDLE = '0;

  // Select field width for a pad with n functions (never below 1 bit).
  function automatic int sel_width(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Low-bit mask with w ones.
  function automatic logic [31:0] width_mask(int w);
    return (32'd1 << w) - 32'd1;
  endfunction

endpackage

// File: rtl/pinmux_regfile.sv
module pinmux_regfile
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 4,
  parameter logic [NUM_PADS*CNT_W-1:0] FUNC_CNTS = {4'd6, 4'd2, 4'd3, 4'd4},
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_LO    = 2,
  parameter int IDX_HI    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic                      acc_err,
  output logic [DATA_W-1:0]         acc_rdata,
  output logic [NUM_PADS*SEL_W-1:0] sel_flat
);

  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0] idx;
  logic             idx_hit;
  logic             wr_hit;
  logic             rd_hit;
  logic             bad_access;
  logic [SEL_W-1:0] sel_q [NUM_PADS];

  logic unused_addr_bits;
  logic unused_data_bits;
  assign unused_addr_bits = ^{acc_addr[ADDR_W-1:IDX_HI+1], acc_addr[IDX_LO-1:0]};
  assign unused_data_bits = ^acc_wdata[DATA_W-1:SEL_W];

  assign idx        = acc_addr[IDX_HI:IDX_LO];
  assign idx_hit    = (32'(idx) < NUM_PADS);
  assign wr_hit     = acc_en && acc_wr && idx_hit;
  assign rd_hit     = acc_en && !acc_wr && idx_hit;
  assign bad_access = acc_en && !idx_hit;
  assign acc_err    = bad_access;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_sel
    localparam int FC = int'(FUNC_CNTS[p*CNT_W +: CNT_W]);
    localparam int W  = sel_width(FC);
    localparam logic [SEL_W-1:0] MASK = SEL_W'(width_mask(W));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[p] <= '0;
      else if (wr_hit && (idx == IDX_W'(p)))
        sel_q[p] <= acc_wdata[SEL_W-1:0] & MASK;
    end

    assign sel_flat[p*SEL_W +: SEL_W] = sel_q[p];

    AST_WRITE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && idx == IDX_W'(p)) |=> (sel_q[p] == ($past(acc_wdata[SEL_W-1:0]) & MASK))); // R2
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_hit)
      acc_rdata = DATA_W'(sel_flat[32'(idx)*SEL_W +: SEL_W]);
  end

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !idx_hit) |=> $stable(sel_flat)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!acc_err && acc_rdata == '0)); // R10
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == '0)); // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (sel_flat == '0)); // R3

endmodule

// File: rtl/pinmux_pad_slice.sv
module pinmux_pad_slice
  import pinmux_pkg::*;
#(
  parameter int MAX_FUNCS = 8,
  parameter int SEL_W     = 3,
  parameter int FUNC_CNT  = 4
) (
  input  logic [SEL_W-1:0]            sel,
  input  logic [MAX_FUNCS*BUNDLE_W-1:0] fn_ctrl,
  input  logic                        pad_in,
  output logic [BUNDLE_W-1:0]         pad_ctrl,
  output logic [MAX_FUNCS-1:0]        fn_in
);

  logic in_range;
  assign in_range = (32'(sel) < FUNC_CNT);

  always_comb begin
    pad_ctrl = SAFE_BUNDLE;
    if (in_range)
      pad_ctrl = fn_ctrl[32'(sel)*BUNDLE_W +: BUNDLE_W];
  end

  for (genvar f = 0; f < MAX_FUNCS; f++) begin : g_fn
    if (f < FUNC_CNT) begin : g_live
      assign fn_in[f] = (in_range && 32'(sel) == f) ? pad_in : 1'b0;
    end else begin : g_dead
      assign fn_in[f] = 1'b0;
    end
  end

  always_comb begin
    AST_IN_ONEHOT: assert ($onehot0(fn_in) || $isunknown(fn_in)); // R9
  end

endmodule

// File: rtl/pad_pinmux.sv
module pad_pinmux
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS  = 4,
  parameter int MAX_FUNCS = 8,
  parameter int CNT_W     = 4,
  parameter logic [NUM_PADS*CNT_W-1:0] FUNC_CNTS = {4'd6, 4'd2, 4'd3, 4'd4},
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_LO    = 2,
  parameter int IDX_HI    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                acc_en,
  input  logic                                acc_wr,
  input  logic [ADDR_W-1:0]                   acc_addr,
  input  logic [DATA_W-1:0]                   acc_wdata,
  output logic                                acc_err,
  output logic [DATA_W-1:0]                   acc_rdata,
  input  logic [NUM_PADS*MAX_FUNCS*BUNDLE_W-1:0] fn_ctrl_i,
  input  logic [NUM_PADS-1:0]                 pad_in_i,
  output logic [NUM_PADS*BUNDLE_W-1:0]        pad_ctrl_o,
  output logic [NUM_PADS*MAX_FUNCS-1:0]       fn_in_o
);

  localparam int SEL_W   = $clog2(MAX_FUNCS);
  localparam int GROUP_W = MAX_FUNCS * BUNDLE_W;

  logic [NUM_PADS*SEL_W-1:0] sel_flat;

  pinmux_regfile #(
    .NUM_PADS (NUM_PADS),
    .SEL_W    (SEL_W),
    .CNT_W    (CNT_W),
    .FUNC_CNTS(FUNC_CNTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_LO   (IDX_LO),
    .IDX_HI   (IDX_HI)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .acc_err  (acc_err),
    .acc_rdata(acc_rdata),
    .sel_flat (sel_flat)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int FC = int'(FUNC_CNTS[p*CNT_W +: CNT_W]);

    logic [SEL_W-1:0]    pad_sel;
    logic [BUNDLE_W-1:0] pad_ctrl;

    assign pad_sel = sel_flat[p*SEL_W +: SEL_W];

    pinmux_pad_slice #(
      .MAX_FUNCS(MAX_FUNCS),
      .SEL_W    (SEL_W),
      .FUNC_CNT (FC)
    ) u_slice (
      .sel     (pad_sel),
      .fn_ctrl (fn_ctrl_i[p*GROUP_W +: GROUP_W]),
      .pad_in  (pad_in_i[p]),
      .pad_ctrl(pad_ctrl),
      .fn_in   (fn_in_o[p*MAX_FUNCS +: MAX_FUNCS])
    );

    assign pad_ctrl_o[p*BUNDLE_W +: BUNDLE_W] = pad_ctrl;

    AST_ROUTE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(pad_sel) < FC) |-> (pad_ctrl == fn_ctrl_i[p*GROUP_W + 32'(pad_sel)*BUNDLE_W +: BUNDLE_W])); // R1
    AST_SAFE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(pad_sel) >= FC) |-> (pad_ctrl == '0 && fn_in_o[p*MAX_FUNCS +: MAX_FUNCS] == '0)); // R8
  end

endmodule

// File: tb/sim_pad_pinmux.sv
module sim_pad_pinmux;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0;
  logic          acc_wr = 1'b0;
  logic [7:0]    acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic          acc_err;
  logic [31:0]   acc_rdata;
  logic [NP*NF*8-1:0] fn_ctrl_i;
  logic [NP-1:0] pad_in_i = '1;
  logic [NP*8-1:0] pad_ctrl_o;
  logic [NP*NF-1:0] fn_in_o;

  int total = 0;
  int bad   = 0;
  int cnt [NP]     = '{4, 3, 2, 6};
  int fld_w [NP]   = '{2, 2, 1, 3};
  int exp_sel [NP] = '{0, 0, 0, 0};

  pad_pinmux u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_err(acc_err),
    .acc_rdata(acc_rdata), .fn_ctrl_i(fn_ctrl_i), .pad_in_i(pad_in_i),
    .pad_ctrl_o(pad_ctrl_o), .fn_in_o(fn_in_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int p, int f);
    return 8'(p*37 + f*11 + 5);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] data, logic [7:0] extra, output logic err);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1;
    acc_addr = 8'(idx << 2) | extra; acc_wdata = data;
    #1 err = acc_err;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(int idx, output logic err, output logic [31:0] data);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 8'(idx << 2);
    #1 err = acc_err; data = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  // Expected pad bundle / input steering from the bench's own select model.
  task automatic chk_pads(string req);
    for (int p = 0; p < NP; p++) begin
      logic [7:0] e;
      logic [NF-1:0] ein;
      e = (exp_sel[p] < cnt[p]) ? pat(p, exp_sel[p]) : 8'h00;
      ein = '0;
      if (exp_sel[p] < cnt[p]) ein[exp_sel[p]] = pad_in_i[p];
      check(pad_ctrl_o[p*8 +: 8] == e, req, $sformatf("pad%0d bundle", p), pad_ctrl_o[p*8 +: 8], e);
      check(fn_in_o[p*NF +: NF] == ein, "R9", $sformatf("pad%0d fn_in", p), fn_in_o[p*NF +: NF], ein);
    end
  endtask

  task automatic chk_regs(string req);
    logic e; logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rd(p, e, d);
      check(e == 1'b0 && d == 32'(exp_sel[p]), req, $sformatf("read idx%0d", p), {e, d}, exp_sel[p]);
    end
  endtask

  task automatic t_reset;
    chk_regs("R3");
    chk_pads("R3");
  endtask

  task automatic t_layout;
    logic [7:0] keep;
    keep = fn_ctrl_i[0 +: 8];
    fn_ctrl_i[0 +: 8] = 8'b1100_0001;
    #1;
    check(pad_ctrl_o[7] == 1'b1 && pad_ctrl_o[6] == 1'b1 && pad_ctrl_o[5:1] == '0 && pad_ctrl_o[0] == 1'b1,
          "R1", "bit order pad0", pad_ctrl_o[7:0], 8'hC1);
    fn_ctrl_i[0 +: 8] = keep;
    #1;
  endtask

  task automatic t_write_read;
    logic e;
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 8'h04; acc_wdata = 32'd2;
    #1;
    check(acc_err == 1'b0, "R5", "write err", acc_err, 0);
    check(pad_ctrl_o[15:8] == pat(1, 0), "R5", "pad1 before edge", pad_ctrl_o[15:8], pat(1, 0));
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    exp_sel[1] = 2;
    check(pad_ctrl_o[15:8] == pat(1, 2), "R5", "pad1 after edge", pad_ctrl_o[15:8], pat(1, 2));
    wr(3, 32'd4, 8'h83, e);  // high and low address bits set, index 3
    exp_sel[3] = 4;
    check(e == 1'b0, "R4", "idx3 with stray address bits", e, 0);
    chk_pads("R4");
    chk_regs("R6");
  endtask

  task automatic t_trunc;
    logic e;
    wr(2, 32'hFF, 8'h00, e); exp_sel[2] = 1;
    wr(0, 32'h1D, 8'h00, e); exp_sel[0] = 1;
    wr(3, 32'hF5, 8'h00, e); exp_sel[3] = 5;
    chk_regs("R2");
    chk_pads("R2");
  endtask

  task automatic t_oob;
    logic e;
    wr(1, 32'd3, 8'h00, e); exp_sel[1] = 3;
    wr(3, 32'd7, 8'h00, e); exp_sel[3] = 7;
    check(pad_ctrl_o[15:8] == 8'h00, "R8", "pad1 code 3", pad_ctrl_o[15:8], 0);
    check(pad_ctrl_o[31:24] == 8'h00, "R8", "pad3 code 7", pad_ctrl_o[31:24], 0);
    chk_pads("R8");
  endtask

  task automatic t_steer;
    logic e;
    wr(1, 32'd1, 8'h00, e); exp_sel[1] = 1;
    wr(3, 32'd2, 8'h00, e); exp_sel[3] = 2;
    pad_in_i = 4'b0101; #1;
    chk_pads("R9");
    pad_in_i = 4'b1010; #1;
    chk_pads("R9");
    pad_in_i = '1; #1;
  endtask

  task automatic t_bad;
    logic e; logic [31:0] d;
    wr(5, 32'd1, 8'h00, e);
    check(e == 1'b1, "R7", "write idx5 err", e, 1);
    rd(7, e, d);
    check(e == 1'b1 && d == 0, "R7", "read idx7", {e, d}, 33'h1_0000_0000);
    chk_regs("R7");
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b1; acc_addr = 8'h00; acc_wdata = 32'd3;
    #1;
    check(acc_err == 1'b0 && acc_rdata == 0, "R10", "idle port", {acc_err, acc_rdata}, 0);
    @(negedge clk);
    acc_wr = 1'b0;
    chk_pads("R10");
    chk_regs("R10");
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int f = 0; f < NF; f++)
        fn_ctrl_i[(p*NF+f)*8 +: 8] = pat(p, f);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_layout;
    t_write_read;
    t_trunc;
    t_oob;
    t_steer;
    t_bad;
    t_idle;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule